// File: doc/BRIEF.md
# Bus-Programmable Permuted Congruential Random Generator

This block is a pseudorandom word source that sits behind a Wishbone classic slave port. It holds a 64-bit state that takes one linear congruential step on every clock, `state <= state * mult + incr` (mod 2^64). It presents a 32-bit output word that is a permutation of that state: a xorshift of the high bits followed by a data-dependent rotation. The raw state is never exposed.

A host programs the generator over the bus. It writes a 32-bit seed to restart the sequence, and it can replace the multiplier and the increment at run time, one 32-bit half at a time. It samples the current output word by reading a fixed offset. Every bus cycle is acknowledged, so the host never stalls on the block.

Top module: `pcg_wb_rng`

## Requirements
- R1: After reset the multiplier reads 0x5851F42D4C957F2D, the increment reads 0x14057B7EF767814F and the state is zero, so the output sequence starts from state 0.
- R2: On each clock that carries no reset and no seed write, the state becomes state × multiplier + increment, truncated to 64 bits, using the multiplier and increment held before that edge.
- R3: The output word is the 32-bit value x = bits [31:0] of (((s >> 18) ^ s) >> 27), rotated right by s[63:59], where s is the state.
- R4: A write to offset 0x00 loads the state with the 32-bit write data, zero-extended, at the edge that accepts the write, replacing the step for that edge; a read of 0x00 returns zero.
- R5: The multiplier low and high halves are read/write at offsets 0x04 and 0x08, the increment low and high halves at 0x0C and 0x10.
- R6: Bit 0 of the increment always reads 1; a write of an even low half stores it with bit 0 set.
- R7: A read of offset 0x14 returns the output register, which holds the permutation of the state from one edge earlier; a read accepted two edges after a seed write returns the permutation of the seed.
- R8: The acknowledge rises one clock after cyc and stb are both high and lasts exactly one cycle; a strobe held high yields an acknowledge every other cycle, never two in a row.
- R9: Reads of unmapped offsets return zero and are acknowledged; writes to unmapped offsets change no register.
- R10: A write to offset 0x14 is acknowledged and changes neither the state nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W (8) | Byte address of the word register |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid while acknowledge is high |
| wb_ack_o | output | 1 | One-cycle acknowledge |

## Verification
A request first sampled at edge E produces its acknowledge and read data after E, so the bench drives on a falling edge and reads both at the next falling edge. A seed write accepted at edge E shows up in the output register at E+1 and is captured by a read accepted at E+2; in general a read accepted at edge R returns the permutation of the state after R−E−2 congruential steps. The bench counts rising edges itself, records the edge index of every seed write and read, and derives each expected output word from that difference with its own step and rotate model.

// File: rtl/pcg_rng_pkg.sv
package pcg_rng_pkg;
  localparam int DATA_W = 32;
  localparam int BYTES  = DATA_W / 8;

  typedef logic [DATA_W-1:0] word_t;

  localparam logic [63:0] PCG_DEF_MULT = 64'h5851_F42D_4C95_7F2D;
  localparam logic [63:0] PCG_DEF_INCR = 64'h1405_7B7E_F767_814F;
endpackage

// File: rtl/pcg_lcg_core.sv
module pcg_lcg_core #(
  parameter int STATE_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [STATE_W-1:0] load_val,
  input  logic [STATE_W-1:0] mult,
  input  logic [STATE_W-1:0] incr,
  output logic [STATE_W-1:0] state
);
  logic [STATE_W-1:0] nxt;

  assign nxt = state * mult + incr;

  always_ff @(posedge clk) begin
    if (rst)       state <= '0;
    else if (load) state <= load_val;
    else           state <= nxt;
  end
endmodule

// File: rtl/pcg_xsh_rr.sv
module pcg_xsh_rr #(
  parameter int STATE_W = 64,
  parameter int OUT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state,
  output logic [OUT_W-1:0]   word
);
  localparam int ROT_W = $clog2(OUT_W);
  localparam int MIX_SH = (OUT_W + ROT_W) / 2;
  localparam int DROP_SH = STATE_W - OUT_W - ROT_W;

  logic [STATE_W-1:0] mixed;
  logic [OUT_W-1:0]   folded;
  logic [ROT_W-1:0]   rot;
  logic [ROT_W-1:0]   lrot;
  logic [OUT_W-1:0]   rotated;

  assign mixed   = ((state >> MIX_SH) ^ state) >> DROP_SH;
  assign folded  = mixed[OUT_W-1:0];
  assign rot     = state[STATE_W-1 -: ROT_W];
  assign lrot    = ~rot + ROT_W'(1);
  assign rotated = (folded >> rot) | (folded << lrot);

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else     word <= rotated;
  end
endmodule

// File: rtl/pcg_wb_regs.sv
module pcg_wb_regs
  import pcg_rng_pkg::*;
#(
  parameter int                 STATE_W  = 64,
  parameter int                 ADDR_W   = 8,
  parameter logic [STATE_W-1:0] DEF_MULT = PCG_DEF_MULT[STATE_W-1:0],
  parameter logic [STATE_W-1:0] DEF_INCR = PCG_DEF_INCR[STATE_W-1:0]
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_i,
  input  logic               stb_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  adr_i,
  input  word_t              dat_i,
  input  word_t              out_word,
  output word_t              dat_o,
  output logic               ack_o,
  output logic [STATE_W-1:0] mult,
  output logic [STATE_W-1:0] incr,
  output logic               seed_ld,
  output logic [STATE_W-1:0] seed_val
);
  localparam int HALVES    = STATE_W / DATA_W;
  localparam int MULT_BASE = BYTES;
  localparam int INCR_BASE = MULT_BASE + HALVES * BYTES;
  localparam int OUT_OFS   = INCR_BASE + HALVES * BYTES;
  localparam logic [ADDR_W-1:0] SEED_A = '0;
  localparam logic [ADDR_W-1:0] OUT_A  = ADDR_W'(OUT_OFS);

  logic  req, wr;
  word_t mult_w [HALVES];
  word_t incr_w [HALVES];
  word_t rd_mux;

  assign req      = cyc_i & stb_i & ~ack_o;
  assign wr       = req & we_i;
  assign seed_ld  = wr && (adr_i == SEED_A);
  assign seed_val = STATE_W'(dat_i);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] MA = ADDR_W'(MULT_BASE + h * BYTES);
    localparam logic [ADDR_W-1:0] IA = ADDR_W'(INCR_BASE + h * BYTES);
    localparam word_t FORCE = (h == 0) ? word_t'(1) : word_t'(0);

    always_ff @(posedge clk) begin
      if (rst)                     mult_w[h] <= DEF_MULT[h*DATA_W +: DATA_W];
      else if (wr && adr_i == MA)  mult_w[h] <= dat_i;
    end

    always_ff @(posedge clk) begin
      if (rst)                     incr_w[h] <= DEF_INCR[h*DATA_W +: DATA_W] | FORCE;
      else if (wr && adr_i == IA)  incr_w[h] <= dat_i | FORCE;
    end

    assign mult[h*DATA_W +: DATA_W] = mult_w[h];
    assign incr[h*DATA_W +: DATA_W] = incr_w[h];
  end

  always_comb begin
    rd_mux = '0;
    if (adr_i == OUT_A) rd_mux = out_word;
    for (int h = 0; h < HALVES; h++) begin
      if (adr_i == ADDR_W'(MULT_BASE + h * BYTES)) rd_mux = mult_w[h];
      if (adr_i == ADDR_W'(INCR_BASE + h * BYTES)) rd_mux = incr_w[h];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      dat_o <= '0;
    end else begin
      ack_o <= req;
      if (req) dat_o <= we_i ? '0 : rd_mux;
    end
  end
endmodule

// File: rtl/pcg_wb_rng.sv
module pcg_wb_rng
  import pcg_rng_pkg::*;
#(
  parameter int STATE_W = 64,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] mult_q;
  logic [STATE_W-1:0] incr_q;
  logic [STATE_W-1:0] seed_val;
  logic               seed_ld;
  word_t              out_word;

  pcg_wb_regs #(.STATE_W(STATE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i),
    .adr_i(wb_adr_i), .dat_i(wb_dat_i), .out_word(out_word),
    .dat_o(wb_dat_o), .ack_o(wb_ack_o),
    .mult(mult_q), .incr(incr_q),
    .seed_ld(seed_ld), .seed_val(seed_val)
  );

  pcg_lcg_core #(.STATE_W(STATE_W)) u_core (
    .clk(clk), .rst(rst),
    .load(seed_ld), .load_val(seed_val),
    .mult(mult_q), .incr(incr_q),
    .state(state_q)
  );

  pcg_xsh_rr #(.STATE_W(STATE_W), .OUT_W(DATA_W)) u_perm (
    .clk(clk), .rst(rst),
    .state(state_q), .word(out_word)
  );
endmodule

// File: rtl/pcg_wb_rng_chk.sv
module pcg_wb_rng_chk #(
  parameter int STATE_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               cyc,
  input logic               stb,
  input logic               ack,
  input logic               load,
  input logic [STATE_W-1:0] load_val,
  input logic [STATE_W-1:0] state,
  input logic [STATE_W-1:0] mult,
  input logic [STATE_W-1:0] incr
);
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(cyc && stb && !ack)); // R8
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R8
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ack) |=> ack); // R8
  AST_INCR_ODD: assert property (@(posedge clk) disable iff (rst)
    incr[0]); // R6
  AST_LCG_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> state == $past(state) * $past(mult) + $past(incr)); // R2
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> state == $past(load_val)); // R4
endmodule

bind pcg_wb_rng pcg_wb_rng_chk #(.STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst(rst), .cyc(wb_cyc_i), .stb(wb_stb_i), .ack(wb_ack_o),
  .load(seed_ld), .load_val(seed_val), .state(state_q),
  .mult(mult_q), .incr(incr_q)
);

// File: tb/pcg_wb_rng_tb.sv
module pcg_wb_rng_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [7:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic        ack;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  int wd = 0;
  bit done = 0;

  logic [63:0] m_mult, m_incr, m_seed;
  int          m_edge;

  pcg_wb_rng u_dut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack)
  );

  always #2 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<100000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] perm(input logic [63:0] s);
    logic [63:0] t;
    logic [31:0] x;
    t = s ^ (s >> 18);
    x = t[58:27];
    for (int i = 0; i < int'(s[63:59]); i++) x = {x[0], x[31:1]};
    return x;
  endfunction

  function automatic logic [31:0] exp_out(input int r_edge);
    logic [63:0] s = m_seed;
    for (int i = 0; i < r_edge - m_edge - 2; i++) s = s * m_mult + m_incr;
    return perm(s);
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output int e);
    cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(negedge clk);
    chk("R8 write ack high", 64'(ack), 64'd1);
    e = edges;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    chk("R8 write ack low", 64'(ack), 64'd0);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output int e);
    cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk);
    chk("R8 read ack high", 64'(ack), 64'd1);
    d = rdat; e = edges;
    cyc = 0; stb = 0;
    @(negedge clk);
    chk("R8 read ack low", 64'(ack), 64'd0);
  endtask

  task automatic seed(input logic [31:0] s);
    int e;
    bus_wr(8'h00, s, e);
    m_seed = 64'(s);
    m_edge = e;
  endtask

  task automatic t_reset;
    logic [31:0] d; int e;
    bus_rd(8'h04, d, e); chk("R1 R5 mult low default", 64'(d), 64'h4C957F2D);
    bus_rd(8'h08, d, e); chk("R1 R5 mult high default", 64'(d), 64'h5851F42D);
    bus_rd(8'h0C, d, e); chk("R1 R5 incr low default", 64'(d), 64'hF767814F);
    bus_rd(8'h10, d, e); chk("R1 R5 incr high default", 64'(d), 64'h14057B7E);
    bus_rd(8'h14, d, e); chk("R1 R3 R7 output from zero state", 64'(d), 64'(exp_out(e)));
  endtask

  task automatic t_sequence;
    logic [31:0] d; int e;
    seed(32'hDEADBEEF);
    bus_rd(8'h14, d, e); chk("R4 R7 output two edges after seed", 64'(d), 64'(perm(64'hDEADBEEF)));
    for (int i = 0; i < 4; i++) begin
      bus_rd(8'h14, d, e); chk("R2 R3 consecutive output", 64'(d), 64'(exp_out(e)));
    end
    bus_rd(8'h00, d, e); chk("R4 seed offset reads zero", 64'(d), 64'd0);
  endtask

  task automatic t_idle_gap;
    logic [31:0] d; int e;
    seed(32'h0000_1234);
    repeat (37) @(negedge clk);
    bus_rd(8'h14, d, e); chk("R2 output after idle gap", 64'(d), 64'(exp_out(e)));
  endtask

  task automatic t_params;
    logic [31:0] d; int e;
    bus_wr(8'h04, 32'h0000_0005, e);
    bus_wr(8'h08, 32'h0000_0000, e);
    bus_wr(8'h0C, 32'h0000_0002, e);
    bus_wr(8'h10, 32'h8000_0000, e);
    m_mult = 64'd5; m_incr = 64'h8000_0000_0000_0003;
    bus_rd(8'h04, d, e); chk("R5 mult low readback", 64'(d), 64'd5);
    bus_rd(8'h08, d, e); chk("R5 mult high readback", 64'(d), 64'd0);
    bus_rd(8'h0C, d, e); chk("R6 incr bit0 forced", 64'(d), 64'd3);
    bus_rd(8'h10, d, e); chk("R5 incr high readback", 64'(d), 64'h8000_0000);
    seed(32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) begin
      bus_rd(8'h14, d, e); chk("R2 output with new mult/incr", 64'(d), 64'(exp_out(e)));
    end
  endtask

  task automatic t_unmapped;
    logic [31:0] d; int e;
    bus_wr(8'h18, 32'hAAAA_5555, e);
    bus_wr(8'hFC, 32'h1234_5678, e);
    bus_wr(8'h14, 32'h0BAD_F00D, e);
    bus_rd(8'h18, d, e); chk("R9 unmapped read zero", 64'(d), 64'd0);
    bus_rd(8'hFC, d, e); chk("R9 unmapped read zero high", 64'(d), 64'd0);
    bus_rd(8'h04, d, e); chk("R9 mult low untouched", 64'(d), 64'd5);
    bus_rd(8'h0C, d, e); chk("R9 incr low untouched", 64'(d), 64'd3);
    bus_rd(8'h14, d, e); chk("R10 output write ignored", 64'(d), 64'(exp_out(e)));
  endtask

  task automatic t_held_strobe;
    cyc = 1; stb = 1; we = 0; adr = 8'h04;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 held strobe ack alternates", 64'(ack), (i % 2 == 0) ? 64'd1 : 64'd0);
      if (i % 2 == 0) chk("R8 held strobe data", 64'(rdat), 64'd5);
    end
    cyc = 0; stb = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 idle after held strobe", 64'(ack), 64'd0);
  endtask

  initial begin
    m_mult = 64'h5851_F42D_4C95_7F2D;
    m_incr = 64'h1405_7B7E_F767_814F;
    m_seed = '0;
    repeat (4) @(negedge clk);
    chk("R8 ack low in reset", 64'(ack), 64'd0);
    chk("R1 read data zero in reset", 64'(rdat), 64'd0);
    rst = 1'b0;
    m_edge = edges;
    t_reset();
    t_sequence();
    t_idle_gap();
    t_params();
    t_unmapped();
    t_held_strobe();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule